// File: doc/BRIEF.md
# Two-Wire Serial EEPROM Slave

This block is the bus-facing logic of an 8K-byte serial EEPROM that answers on a two-wire bus. SCL and SDA arrive already synchronised to the faster system clock. The block watches them for start and stop conditions and checks the device address byte against a fixed family code and three strap inputs. On a match it takes a 13-bit memory address in two bytes. It then either collects write data or streams read data from an address counter that advances on its own. The block pulls SDA low through an open-drain enable and never drives it high.

Writes pass through a 32-byte page buffer. Successive data bytes land at consecutive offsets and wrap inside the addressed page. The buffer is copied into the array only after a stop condition, and the copy takes one system clock per page slot. A write-protect input blocks that copy whenever the page lies in the top quarter of the array. Reads run across page boundaries and wrap at the end of the array. A read ends when the master leaves the ninth clock unacknowledged.

Top module: `i2c_eeprom_slave`

## Requirements
- R1: After reset the SDA pull-down enable is inactive and the block waits for a start condition.
- R2: A start (SDA falls while SCL is high) begins a new transfer from any state, including in the middle of a byte. A stop (SDA rises while SCL is high) returns the block to idle from any state.
- R3: The device address byte, MSB first, is 1010, then strap[2:0], then a direction bit (1 = read). On a match the block pulls SDA low on the ninth clock. On a mismatch it leaves SDA released and ignores all further bytes until the next start.
- R4: In a write transfer, SDA is pulled low on the ninth clock after the device address byte, after both memory address bytes and after every data byte. In those states it is never pulled low outside the ninth clock.
- R5: The memory address is sent high byte first. The three top bits of the high byte are ignored.
- R6: Data bytes of one write go to consecutive offsets within the 32-byte page. The low five address bits wrap from 31 to 0. A later byte at the same offset replaces an earlier one.
- R7: The buffered bytes reach the array only after a stop condition, and the copy finishes within 32 system clocks. A repeated start before the stop discards them.
- R8: In a read, data bytes are sent MSB first starting at the address counter. The counter advances after each byte, and the transfer continues while the master pulls SDA low on the ninth clock. The counter wraps from 0x1FFF to 0x0000.
- R9: If the master leaves SDA high on the ninth clock of a read byte, the block releases SDA and stays silent until the next start.
- R10: While wp is 1, buffered bytes for addresses 0x1800 to 0x1FFF are not written, although every byte is still acknowledged. Lower addresses are written whatever the level of wp, and wp at 0 allows every address.
- R11: The SDA pull-down enable changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, faster than SCL |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl | input | 1 | Serial clock, synchronised to clk |
| sda_in | input | 1 | Serial data line level, synchronised to clk |
| strap | input | 3 | Device address straps, tie low if unused |
| wp | input | 1 | Write protect for the top quarter, tie low if unused |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |

## Verification
The embedded properties watch, on every cycle, several things: the pull-down enable stays still while SCL is high; it stays inactive outside the ninth clock during receive and whenever the block idles; a stop always forces idle; and an array write into the protected quarter never happens while wp is high. Whether the right data reaches the right address, how page wrap and counter rollover behave, whether a repeated start discards buffered data, and what a mismatched address or a master's missing acknowledge does to the bus all involve whole transfers. Only the bench's directed and random scenarios, compared against its own memory model, can show those.

// File: rtl/i2c_eeprom_slave.sv
module i2c_eeprom_slave #(
  parameter int ADDR_W = 13,
  parameter int PAGE_W = 5,
  parameter logic [3:0] FAMILY = 4'b1010
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl,
  input  logic       sda_in,
  input  logic [2:0] strap,
  input  logic       wp,
  output logic       sda_oe
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int PB_W  = ADDR_W - PAGE_W;
  localparam int HI_W  = ADDR_W - 8;
  localparam logic [ADDR_W-1:0] GUARD_LO = ADDR_W'(DEPTH / 4 * 3);

  typedef enum logic [2:0] {S_IDLE, S_DEV, S_AHI, S_ALO, S_WR, S_RD} st_t;
  st_t st;

  logic              scl_q, sda_q;
  logic [3:0]        bitcnt;
  logic [7:0]        shreg, txreg;
  logic [HI_W-1:0]   hi_q;
  logic              rw, mack, wr_pend, cmt_busy;
  logic [ADDR_W-1:0] addr;
  logic [PB_W-1:0]   pbase, cmt_base;
  logic [PAGE_W-1:0] cmt_idx;
  logic [PAGE-1:0]   pvld;
  logic [7:0]        pbuf [PAGE];
  logic [7:0]        mem  [DEPTH];

  logic scl_rise, scl_fall, start_det, stop_det, dev_hit, buf_we, mem_we;
  logic [PAGE_W-1:0] wofs;
  logic [ADDR_W-1:0] new_addr, mem_wa;
  logic [7:0]        rd_byte;

  assign scl_rise  = scl & ~scl_q;
  assign scl_fall  = ~scl & scl_q;
  assign start_det = scl & scl_q & sda_q & ~sda_in;
  assign stop_det  = scl & scl_q & ~sda_q & sda_in;
  assign dev_hit   = shreg[7:1] == {FAMILY, strap};
  assign wofs      = addr[PAGE_W-1:0];
  assign new_addr  = {hi_q, shreg};
  assign rd_byte   = mem[addr];
  assign mem_wa    = {cmt_base, cmt_idx};
  assign buf_we    = (st == S_WR) & scl_fall & (bitcnt == 4'd8) & ~start_det & ~stop_det;
  assign mem_we    = cmt_busy & pvld[cmt_idx] & ~(wp & (&cmt_base[PB_W-1 -: 2]));

  always_ff @(posedge clk) begin
    if (buf_we) pbuf[wofs] <= shreg;
  end

  always_ff @(posedge clk) begin
    if (mem_we) mem[mem_wa] <= pbuf[cmt_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      sda_q    <= 1'b1;
      st       <= S_IDLE;
      bitcnt   <= '0;
      shreg    <= '0;
      txreg    <= '0;
      hi_q     <= '0;
      rw       <= 1'b0;
      mack     <= 1'b0;
      wr_pend  <= 1'b0;
      cmt_busy <= 1'b0;
      cmt_idx  <= '0;
      cmt_base <= '0;
      addr     <= '0;
      pbase    <= '0;
      pvld     <= '0;
      sda_oe   <= 1'b0;
    end else begin
      scl_q <= scl;
      sda_q <= sda_in;
      if (cmt_busy) begin
        cmt_idx <= cmt_idx + 1'b1;
        if (&cmt_idx) cmt_busy <= 1'b0;
      end
      if (start_det) begin
        st      <= S_DEV;
        bitcnt  <= '0;
        sda_oe  <= 1'b0;
        wr_pend <= 1'b0;
      end else if (stop_det) begin
        st      <= S_IDLE;
        bitcnt  <= '0;
        sda_oe  <= 1'b0;
        if (wr_pend) begin
          cmt_busy <= 1'b1;
          cmt_idx  <= '0;
          cmt_base <= pbase;
          wr_pend  <= 1'b0;
        end
      end else if (st != S_IDLE) begin
        if (scl_rise) begin
          if (bitcnt < 4'd8) begin
            bitcnt <= bitcnt + 1'b1;
            if (st != S_RD) shreg <= {shreg[6:0], sda_in};
          end else if (st == S_RD) begin
            mack <= ~sda_in;
          end
        end
        if (scl_fall) begin
          if (st == S_RD) begin
            if (bitcnt == 4'd8) begin
              sda_oe <= 1'b0;
              bitcnt <= 4'd9;
              addr   <= addr + 1'b1;
            end else if (bitcnt == 4'd9) begin
              bitcnt <= '0;
              if (mack) begin
                txreg  <= rd_byte;
                sda_oe <= ~rd_byte[7];
              end else begin
                st     <= S_IDLE;
                sda_oe <= 1'b0;
              end
            end else if (bitcnt != 4'd0) begin
              txreg  <= {txreg[6:0], 1'b0};
              sda_oe <= ~txreg[6];
            end
          end else if (bitcnt == 4'd8) begin
            bitcnt <= 4'd9;
            sda_oe <= 1'b1;
            case (st)
              S_DEV: begin
                if (dev_hit) begin
                  rw <= shreg[0];
                end else begin
                  st     <= S_IDLE;
                  sda_oe <= 1'b0;
                  bitcnt <= '0;
                end
              end
              S_AHI: hi_q <= shreg[HI_W-1:0];
              S_ALO: begin
                addr  <= new_addr;
                pbase <= new_addr[ADDR_W-1:PAGE_W];
                pvld  <= '0;
              end
              default: begin
                pvld[wofs]            <= 1'b1;
                wr_pend               <= 1'b1;
                addr[PAGE_W-1:0]      <= wofs + 1'b1;
              end
            endcase
          end else if (bitcnt == 4'd9) begin
            sda_oe <= 1'b0;
            bitcnt <= '0;
            case (st)
              S_DEV: begin
                if (rw) begin
                  st     <= S_RD;
                  txreg  <= rd_byte;
                  sda_oe <= ~rd_byte[7];
                end else begin
                  st <= S_AHI;
                end
              end
              S_AHI:   st <= S_ALO;
              default: st <= S_WR;
            endcase
          end
        end
      end
    end
  end

  // R11
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (scl && scl_q) |-> $stable(sda_oe));

  // R2
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> st == S_IDLE);

  // R9
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE) |-> !sda_oe);

  // R4
  ack_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((st inside {S_DEV, S_AHI, S_ALO, S_WR}) && bitcnt != 4'd9) |-> !sda_oe);

  // R10
  wp_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !(wp && mem_wa >= GUARD_LO));

  // R7
  commit_after_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cmt_busy) |-> $past(stop_det));
endmodule

// File: tb/i2c_eeprom_slave_bench.sv
module i2c_eeprom_slave_bench;
  localparam int Q = 4;

  logic clk = 1'b0, rst_n = 1'b0, m_scl = 1'b1, m_sda = 1'b1, wp_v = 1'b0;
  logic [2:0] strap_v = 3'b010;
  logic sda_oe, sda_line;
  assign sda_line = m_sda & ~sda_oe;

  always #2 clk = ~clk;

  i2c_eeprom_slave u_i2c_eeprom_slave (
    .clk(clk), .rst_n(rst_n), .scl(m_scl), .sda_in(sda_line),
    .strap(strap_v), .wp(wp_v), .sda_oe(sda_oe));

  int checks = 0, failures = 0, oe_viol = 0;
  bit done = 1'b0;
  logic [7:0] model [8192];
  bit         known [8192];
  logic [7:0] wdata [64];
  logic prev_scl = 1'b1, prev_oe = 1'b0;

  always @(posedge clk) begin
    #1;
    if (rst_n && m_scl && prev_scl && sda_oe !== prev_oe) oe_viol++;
    prev_scl = m_scl;
    prev_oe  = sda_oe;
  end

  function automatic logic [12:0] pg(input logic [12:0] a, input int i);
    return {a[12:5], 5'(int'(a[4:0]) + i)};
  endfunction

  function automatic bit blocked(input logic [12:0] a, input logic w);
    return w && (a >= 13'h1800);
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq;
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq; m_scl = 1'b1; wq; m_sda = 1'b0; wq; m_scl = 1'b0; wq;
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq; m_scl = 1'b1; wq; m_sda = 1'b1; wq;
    repeat (48) @(negedge clk);
  endtask

  task automatic clock_bit(input logic b);
    m_sda = b; wq; m_scl = 1'b1; wq; wq; m_scl = 1'b0; wq;
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) clock_bit(b[i]);
    m_sda = 1'b1; wq; m_scl = 1'b1; wq;
    ack = (sda_line == 1'b0);
    wq; m_scl = 1'b0; wq;
  endtask

  task automatic recv_byte(input bit mack, output logic [7:0] b);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq; m_scl = 1'b1; wq; b[i] = sda_line; wq; m_scl = 1'b0; wq;
    end
    m_sda = mack ? 1'b0 : 1'b1;
    wq; m_scl = 1'b1; wq; wq; m_scl = 1'b0; wq;
    m_sda = 1'b1;
  endtask

  task automatic send_addr(input logic [12:0] a, input logic [2:0] junk, input string tag);
    bit ack;
    send_byte({4'hA, strap_v, 1'b0}, ack); chk(ack, {tag, " R3 dev ack"}, ack, 1);
    send_byte({junk, a[12:8]}, ack);       chk(ack, "R4 R5 high addr ack", ack, 1);
    send_byte(a[7:0], ack);                chk(ack, "R4 low addr ack", ack, 1);
  endtask

  task automatic write_page(input logic [12:0] a, input int n, input logic [2:0] junk, input string tag);
    bit ack;
    logic [12:0] ea;
    bus_start;
    send_addr(a, junk, tag);
    for (int i = 0; i < n; i++) begin
      send_byte(wdata[i], ack);
      chk(ack, "R4 data ack", ack, 1);
      ea = pg(a, i);
      if (!blocked(ea, wp_v)) begin
        model[ea] = wdata[i];
        known[ea] = 1'b1;
      end
    end
    bus_stop;
  endtask

  task automatic read_seq(input logic [12:0] a, input int n, input string tag);
    bit ack;
    logic [7:0] d;
    logic [12:0] ea;
    bus_start;
    send_addr(a, 3'b000, tag);
    bus_start;
    send_byte({4'hA, strap_v, 1'b1}, ack);
    chk(ack, "R3 read dev ack", ack, 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i != n - 1, d);
      ea = a + 13'(i);
      if (known[ea]) chk(d === model[ea], tag, int'(d), int'(model[ea]));
    end
    bus_stop;
  endtask

  initial begin
    bit ack;
    logic [7:0] d;
    logic [12:0] a;
    int n;
    void'($urandom(32'h5EED));
    repeat (5) @(negedge clk);
    chk(sda_oe === 1'b0, "R1 reset release", int'(sda_oe), 0);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk(sda_oe === 1'b0, "R1 idle after reset", int'(sda_oe), 0);

    // R3: wrong straps and wrong family code are not acknowledged
    bus_start;
    send_byte({4'hA, strap_v ^ 3'b101, 1'b0}, ack);
    chk(!ack, "R3 strap mismatch nack", ack, 0);
    send_byte(8'h00, ack);
    chk(!ack, "R3 ignored after mismatch", ack, 0);
    bus_stop;
    bus_start;
    send_byte({4'hB, strap_v, 1'b0}, ack);
    chk(!ack, "R3 family mismatch nack", ack, 0);
    bus_stop;

    // R5: single byte write with junk upper bits, read back
    wdata[0] = 8'h3C;
    write_page(13'h0123, 1, 3'b111, "R5");
    read_seq(13'h0123, 1, "R5 byte readback");

    // R6: page wrap within page 0x0A00, neighbour page untouched
    wdata[0] = 8'h77; write_page(13'h0A20, 1, 3'b000, "R6");
    for (int i = 0; i < 4; i++) wdata[i] = 8'h10 + 8'(i);
    write_page(13'h0A1E, 4, 3'b000, "R6");
    read_seq(13'h0A1E, 4, "R6 wrap no spill");
    read_seq(13'h0A00, 2, "R6 wrap low offsets");

    // R7: repeated start discards buffered bytes
    wdata[0] = 8'h01; wdata[1] = 8'h02; write_page(13'h0100, 2, 3'b000, "R7");
    bus_start;
    send_addr(13'h0100, 3'b000, "R7");
    send_byte(8'h5A, ack); send_byte(8'hA5, ack);
    bus_start;
    send_addr(13'h0200, 3'b000, "R7");
    bus_stop;
    read_seq(13'h0100, 2, "R7 discard on restart");

    // R10: write protect
    wp_v = 1'b0; wdata[0] = 8'hAA; write_page(13'h1900, 1, 3'b000, "R10");
    wdata[0] = 8'hAB; write_page(13'h1800, 1, 3'b000, "R10");
    wp_v = 1'b1; wdata[0] = 8'h55; write_page(13'h1900, 1, 3'b000, "R10");
    wdata[0] = 8'h56; write_page(13'h1800, 1, 3'b000, "R10");
    wdata[0] = 8'h66; write_page(13'h17FF, 1, 3'b000, "R10");
    wp_v = 1'b0;
    read_seq(13'h1900, 1, "R10 protected kept");
    read_seq(13'h1800, 1, "R10 boundary kept");
    read_seq(13'h17FF, 1, "R10 below boundary written");
    chk(model[13'h1900] == 8'hAA, "R10 model", int'(model[13'h1900]), 8'hAA);

    // R8: sequential read with rollover
    wdata[0] = 8'hE1; wdata[1] = 8'hE2; write_page(13'h1FFE, 2, 3'b000, "R8");
    wdata[0] = 8'h91; wdata[1] = 8'h92; write_page(13'h0000, 2, 3'b000, "R8");
    read_seq(13'h1FFE, 4, "R8 rollover");

    // R9: master nack ends read, slave silent afterwards
    bus_start;
    send_addr(13'h1FFE, 3'b000, "R9");
    bus_start;
    send_byte({4'hA, strap_v, 1'b1}, ack);
    recv_byte(1'b0, d);
    chk(d === 8'hE1, "R9 data before nack", int'(d), 8'hE1);
    for (int i = 0; i < 9; i++) begin
      m_sda = 1'b1; wq; m_scl = 1'b1; wq;
      chk(sda_line === 1'b1, "R9 released after nack", int'(sda_line), 1);
      wq; m_scl = 1'b0; wq;
    end
    bus_stop;

    // R2: start in the middle of a byte restarts the transfer
    bus_start;
    send_byte({4'hA, strap_v, 1'b0}, ack);
    for (int i = 0; i < 4; i++) clock_bit(1'b0);
    wdata[0] = 8'hC7; write_page(13'h0456, 1, 3'b000, "R2");
    read_seq(13'h0456, 1, "R2 mid-byte restart");

    // random page writes and readback
    for (int it = 0; it < 6; it++) begin
      strap_v = 3'($urandom);
      wp_v = 1'($urandom);
      a = 13'($urandom);
      n = 1 + int'($urandom % 36);
      for (int j = 0; j < n; j++) wdata[j] = 8'($urandom);
      write_page(a, n, 3'($urandom), "R6");
      wp_v = 1'b0;
      read_seq({a[12:5], 5'd0}, 32, "R8 random readback");
    end

    chk(oe_viol == 0, "R11 enable only changes with SCL low", oe_viol, 0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog R2 actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule